// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block turns a configuration-space request into the memory access that carries it on the system side. A request names a bus, a device, a function, a register offset, an access size of 1, 2 or 4 bytes, a direction, and write data where the request is a write. On bus 0 the block forms a type 0 address. That address uses a one-hot device select: the select bits that fall under the window mask go to the upper window register, and the rest stay in the address. On any other bus it forms a packed type 1 address. The window register holds a configuration code and any select bits that belong to it. The block exposes this register as a port so that the address decoder beside it can use the value.

The block drives a memory port with a request/acknowledge handshake. Read data comes back shifted down to the byte lanes that were asked for. A 4-byte write is stored directly. A 1- or 2-byte write reads the word, merges the new bytes into it and writes the word back. A request that cannot be mapped is answered at once with an error and causes no memory access. An error that the bus signals during an access is answered with all-ones data.

Top module: `cfgaddr_xlate`

## Requirements
- R1: With bus number 0 and a mappable request, the memory address is CFG_BASE OR (bit (device+16) set, keeping only the bits outside WIN_MASK) OR (function << 8) OR (offset with bits 1:0 cleared).
- R2: When a mappable bus-0 request is accepted, win_val becomes T0_CODE OR (bit (device+16) set, keeping only the bits inside WIN_MASK). The value is visible one cycle after acceptance and does not change again before the next accepted request.
- R3: With a nonzero bus number, the address is CFG_BASE OR (bus << 16) OR (device << 11) OR (function << 8) OR (offset with bits 1:0 cleared), and win_val becomes T1_CODE. On these buses, device numbers of 16 and above are allowed.
- R4: A bus-0 request with a device number of SLOT_MAX (16) or more is answered with rsp_err = 1, makes no memory access and leaves win_val unchanged.
- R5: While cardbus_mode is 1, a request for any device other than 0 is rejected in the same way as in R4, on every bus.
- R6: A size other than 1, 2 or 4 (the size is a byte count) is rejected in the same way as in R4.
- R7: A read makes one memory read and returns the word shifted right by 8 × (offset mod 4). Only the low 8, 16 or 32 bits are kept, according to the size, and the upper bits are zero.
- R8: A 4-byte write makes a single memory write of req_wdata. A 1- or 2-byte write reads the word first, replaces the bytes starting at lane (offset mod 4) with the low bytes of req_wdata, keeps the other bytes, and writes the merged word back. A write response carries rsp_rdata = 0.
- R9: When mem_err is 1 with mem_ack, the access is abandoned. The response carries rsp_err = 1 and rsp_rdata = all ones, and a partial write then writes nothing. Rejected requests (R4 to R6) also return all ones.
- R10: busy is 1 from the cycle after acceptance up to and including the single rsp_valid cycle. A req_valid seen while busy is ignored: it produces no access, no window change and no extra response.
- R11: After reset the block is idle. busy, mem_req and rsp_valid are 0 and win_val is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cardbus_mode | input | 1 | Only device 0 is reachable |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | BUS_W | Bus number |
| req_dev | input | DEV_W | Device number |
| req_func | input | FUNC_W | Function number |
| req_off | input | OFF_W | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, low-aligned |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request rejected or bus error |
| rsp_rdata | output | 32 | Aligned read data |
| win_val | output | 32 | Upper window register value |
| mem_req | output | 1 | Memory access request, held until ack |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access done |
| mem_err | input | 1 | Bus error with ack |
| mem_rdata | input | 32 | Memory read data, valid with ack |

## Verification
The bench builds the block with its defaults: SLOT_MAX of 16, a window mask covering bits 31:26, and the cardbus restriction built in. With these values, devices 0 to 9 place their select bit in the address and devices 10 to 15 place it in the window register, so both halves of the one-hot split are checked. Devices 16 and up sit just past the type 0 limit, where they must be rejected, and on a nonzero bus the same numbers must still be accepted. The memory model signals a bus error whenever address bits 10:8 are all ones, which lets a chosen function number trigger the error on a read, a full write or a partial write.

// File: rtl/cfgx_pkg.sv
`timescale 1ns/1ps
package cfgx_pkg;
   localparam int DATA_W = 32;
   localparam int NBYTES = DATA_W / 8;
   localparam int LANE_W = $clog2(NBYTES);

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2,
      ST_RSP  = 2'd3
   } cfgx_state_t;

   typedef struct packed {
      logic              wr;
      logic [LANE_W-1:0] lane;
      logic [2:0]        size;
      logic [DATA_W-1:0] wdata;
   } cfgx_req_t;
endpackage

// File: rtl/cfgx_decode.sv
`timescale 1ns/1ps
module cfgx_decode #(
   parameter int          BUS_W         = 8,
   parameter int          DEV_W         = 5,
   parameter int          FUNC_W        = 3,
   parameter int          OFF_W         = 8,
   parameter int          SLOT_MAX      = 16,
   parameter bit          CARDBUS_CHECK = 1'b1,
   parameter logic [31:0] CFG_BASE      = 32'h0C00_0000,
   parameter logic [31:0] WIN_MASK      = 32'hFC00_0000,
   parameter logic [31:0] T0_CODE       = 32'h0000_0002,
   parameter logic [31:0] T1_CODE       = 32'h0000_0003
) (
   input  logic [BUS_W-1:0]  bus,
   input  logic [DEV_W-1:0]  dev,
   input  logic [FUNC_W-1:0] func,
   input  logic [OFF_W-1:0]  off,
   input  logic [2:0]        size,
   input  logic              cardbus,
   output logic [31:0]       addr,
   output logic [31:0]       win,
   output logic              ok
);
   localparam int SEL_LO = 16;
   localparam int SEL_HI = SEL_LO + SLOT_MAX;

   initial begin
      if (SEL_HI > 32) $fatal(1, "SLOT_MAX too large for a 32-bit select");
      if ((1 << DEV_W) < SLOT_MAX) $fatal(1, "DEV_W too narrow for SLOT_MAX");
      if (16 + BUS_W > 32) $fatal(1, "BUS_W overflows the type 1 address");
      if (FUNC_W > 3 || OFF_W != 8) $fatal(1, "function or offset width unsupported");
   end

   logic [31:0] onehot;
   logic [31:0] off_word;
   logic [31:0] fn_bits;
   logic        is_t0;
   logic        dev_fits;
   logic        size_ok;
   logic        cb_ok;

   for (genvar b = 0; b < 32; b++) begin : g_sel
      if (b >= SEL_LO && b < SEL_HI) begin : g_on
         assign onehot[b] = (dev == DEV_W'(b - SEL_LO));
      end else begin : g_off
         assign onehot[b] = 1'b0;
      end
   end

   if (CARDBUS_CHECK) begin : g_cb
      assign cb_ok = !cardbus || (dev == '0);
   end else begin : g_nocb
      assign cb_ok = 1'b1;
   end

   assign off_word = 32'({off[OFF_W-1:2], 2'b00});
   assign fn_bits  = 32'(func) << 8;
   assign is_t0    = (bus == '0);
   assign dev_fits = (32'(dev) < 32'(SLOT_MAX));
   assign size_ok  = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
   assign ok       = size_ok && cb_ok && (!is_t0 || dev_fits);

   always_comb begin
      if (is_t0) begin
         addr = CFG_BASE | (onehot & ~WIN_MASK) | fn_bits | off_word;
         win  = T0_CODE | (onehot & WIN_MASK);
      end else begin
         addr = CFG_BASE | (32'(bus) << 16) | (32'(dev) << 11) | fn_bits | off_word;
         win  = T1_CODE;
      end
   end
endmodule

// File: rtl/cfgx_lanes.sv
`timescale 1ns/1ps
module cfgx_lanes
   import cfgx_pkg::*;
(
   input  logic [DATA_W-1:0] word,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LANE_W-1:0] lane,
   input  logic [2:0]        size,
   output logic [DATA_W-1:0] rd_al,
   output logic [DATA_W-1:0] merged
);
   logic [LANE_W+2:0] shamt;
   logic [DATA_W-1:0] rsh;
   logic [DATA_W-1:0] wsh;
   logic [NBYTES-1:0] hit;

   assign shamt = {lane, 3'b000};
   assign rsh   = word >> shamt;
   assign wsh   = wdata << shamt;

   always_comb begin
      case (size)
         3'd1:    rd_al = {{(DATA_W-8){1'b0}},  rsh[7:0]};
         3'd2:    rd_al = {{(DATA_W-16){1'b0}}, rsh[15:0]};
         default: rd_al = rsh;
      endcase
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign hit[b] = (b >= int'(lane)) && (b < int'(lane) + int'(size));
      assign merged[8*b +: 8] = hit[b] ? wsh[8*b +: 8] : word[8*b +: 8];
   end
endmodule

// File: rtl/cfgaddr_xlate.sv
`timescale 1ns/1ps
module cfgaddr_xlate
   import cfgx_pkg::*;
#(
   parameter int          BUS_W         = 8,
   parameter int          DEV_W         = 5,
   parameter int          FUNC_W        = 3,
   parameter int          OFF_W         = 8,
   parameter int          SLOT_MAX      = 16,
   parameter bit          CARDBUS_CHECK = 1'b1,
   parameter logic [31:0] CFG_BASE      = 32'h0C00_0000,
   parameter logic [31:0] WIN_MASK      = 32'hFC00_0000,
   parameter logic [31:0] T0_CODE       = 32'h0000_0002,
   parameter logic [31:0] T1_CODE       = 32'h0000_0003
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cardbus_mode,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [BUS_W-1:0]  req_bus,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [FUNC_W-1:0] req_func,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [2:0]        req_size,
   input  logic [31:0]       req_wdata,
   output logic              busy,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata,
   output logic [31:0]       win_val,
   output logic              mem_req,
   output logic              mem_we,
   output logic [31:0]       mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic [31:0]       mem_rdata
);
   cfgx_state_t state_q;
   cfgx_req_t   req_q;
   logic [31:0] addr_q;
   logic [31:0] win_q;
   logic [31:0] wbuf_q;
   logic [31:0] rdata_q;
   logic        err_q;

   logic [31:0] dec_addr;
   logic [31:0] dec_win;
   logic        dec_ok;
   logic [31:0] lane_rd;
   logic [31:0] lane_mrg;
   logic        full_wr;

   cfgx_decode #(
      .BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W), .OFF_W(OFF_W),
      .SLOT_MAX(SLOT_MAX), .CARDBUS_CHECK(CARDBUS_CHECK),
      .CFG_BASE(CFG_BASE), .WIN_MASK(WIN_MASK),
      .T0_CODE(T0_CODE), .T1_CODE(T1_CODE)
   ) u_dec (
      .bus(req_bus), .dev(req_dev), .func(req_func), .off(req_off),
      .size(req_size), .cardbus(cardbus_mode),
      .addr(dec_addr), .win(dec_win), .ok(dec_ok)
   );

   cfgx_lanes u_lanes (
      .word(mem_rdata), .wdata(req_q.wdata), .lane(req_q.lane),
      .size(req_q.size), .rd_al(lane_rd), .merged(lane_mrg)
   );

   assign full_wr = req_write && (req_size == 3'd4);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         req_q   <= '0;
         addr_q  <= '0;
         win_q   <= '0;
         wbuf_q  <= '0;
         rdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  req_q.wr    <= req_write;
                  req_q.lane  <= req_off[LANE_W-1:0];
                  req_q.size  <= req_size;
                  req_q.wdata <= req_wdata;
                  if (dec_ok) begin
                     addr_q  <= dec_addr;
                     win_q   <= dec_win;
                     wbuf_q  <= req_wdata;
                     state_q <= full_wr ? ST_WR : ST_RD;
                  end else begin
                     err_q   <= 1'b1;
                     rdata_q <= '1;
                     state_q <= ST_RSP;
                  end
               end
            end
            ST_RD: begin
               if (mem_ack) begin
                  if (mem_err) begin
                     err_q   <= 1'b1;
                     rdata_q <= '1;
                     state_q <= ST_RSP;
                  end else if (req_q.wr) begin
                     wbuf_q  <= lane_mrg;
                     state_q <= ST_WR;
                  end else begin
                     err_q   <= 1'b0;
                     rdata_q <= lane_rd;
                     state_q <= ST_RSP;
                  end
               end
            end
            ST_WR: begin
               if (mem_ack) begin
                  err_q   <= mem_err;
                  rdata_q <= mem_err ? '1 : '0;
                  state_q <= ST_RSP;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign rsp_valid = (state_q == ST_RSP);
   assign rsp_err   = err_q;
   assign rsp_rdata = rdata_q;
   assign win_val   = win_q;
   assign mem_req   = (state_q == ST_RD) || (state_q == ST_WR);
   assign mem_we    = (state_q == ST_WR);
   assign mem_addr  = addr_q;
   assign mem_wdata = wbuf_q;
endmodule

// File: rtl/cfgx_chk.sv
`timescale 1ns/1ps
module cfgx_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        rsp_valid,
   input logic        rsp_err,
   input logic [31:0] rsp_rdata,
   input logic [31:0] win_val,
   input logic        mem_req,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic        mem_ack,
   input logic        mem_err
);
   AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00)); // R1
   AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(win_val)); // R2
   AST_ERR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_rdata == 32'hFFFF_FFFF)); // R9
   AST_BERR_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_err) |=> (rsp_valid && rsp_err)); // R9
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R8
   AST_RMW_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && !mem_we && !mem_err) |=> (rsp_valid || (mem_req && mem_we))); // R8
   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !rsp_valid)); // R10
endmodule

bind cfgaddr_xlate cfgx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid),
   .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .win_val(win_val),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_ack(mem_ack), .mem_err(mem_err)
);

// File: tb/sim_cfgaddr_xlate.sv
`timescale 1ns/1ps
module sim_cfgaddr_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cardbus_mode = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_func = '0;
   logic [7:0]  req_off = '0;
   logic [2:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        busy, rsp_valid, rsp_err, mem_req, mem_we;
   logic [31:0] rsp_rdata, win_val, mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic        mem_err = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #5 clk = ~clk;

   cfgaddr_xlate u0 (
      .clk(clk), .rst_n(rst_n), .cardbus_mode(cardbus_mode),
      .req_valid(req_valid), .req_write(req_write), .req_bus(req_bus),
      .req_dev(req_dev), .req_func(req_func), .req_off(req_off),
      .req_size(req_size), .req_wdata(req_wdata), .busy(busy),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .win_val(win_val), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_err(mem_err), .mem_rdata(mem_rdata)
   );

   int          n_cmp = 0;
   int          n_bad = 0;
   bit          run = 1'b0;
   logic [31:0] exp_win = '0;

   task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   // memory model: words in an associative array, default content hashed from address
   logic [31:0] mem [logic [31:0]];
   int          rd_n = 0, wr_n = 0;
   logic [31:0] last_addr = '0;
   int          lat = 1;
   int          wcnt = 0;

   function automatic logic [31:0] peek(input logic [31:0] a);
      if (mem.exists(a)) return mem[a];
      return (a * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
   endfunction

   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
         mem_err = 1'b0;
      end else if (mem_req) begin
         if (wcnt >= lat) begin
            wcnt = 0;
            mem_ack = 1'b1;
            mem_err = (mem_addr[10:8] == 3'b111);
            last_addr = mem_addr;
            if (mem_we) begin
               wr_n++;
               if (!mem_err) mem[mem_addr] = mem_wdata;
               mem_rdata = 32'h1234_5678;
            end else begin
               rd_n++;
               mem_rdata = mem_err ? 32'h1234_5678 : peek(mem_addr);
            end
         end else wcnt++;
      end
   end

   // per-clock comparison of the window register and handshake sanity
   always @(negedge clk) begin
      if (run) begin
         chk(win_val === exp_win, "R2 window per clock", win_val, exp_win);
         chk(!(mem_req && !busy), "R10 access only while busy", {31'd0, mem_req}, 32'd0);
      end
   end

   // reference model
   function automatic bit m_ok(int bus, int dev, int size, bit cb);
      if (!(size == 1 || size == 2 || size == 4)) return 1'b0;
      if (cb && dev != 0) return 1'b0;
      if (bus == 0 && dev >= 16) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic [31:0] m_addr(int bus, int dev, int func, int off);
      logic [31:0] a;
      a = 32'h0C00_0000 | (func << 8) | (off & 32'hFC);
      if (bus == 0) a = a | ((32'd1 << (dev + 16)) & 32'h03FF_FFFF);
      else a = a | (bus << 16) | (dev << 11);
      return a;
   endfunction

   function automatic logic [31:0] m_win(int bus, int dev);
      if (bus == 0) return 32'h2 | ((32'd1 << (dev + 16)) & 32'hFC00_0000);
      return 32'h3;
   endfunction

   function automatic logic [31:0] m_read(logic [31:0] w, int off, int size);
      logic [31:0] s;
      s = w >> (8 * (off % 4));
      if (size == 1) return s & 32'hFF;
      if (size == 2) return s & 32'hFFFF;
      return s;
   endfunction

   function automatic logic [31:0] m_merge(logic [31:0] w, logic [31:0] d, int off, int size);
      logic [31:0] r;
      r = w;
      for (int i = 0; i < size; i++) begin
         int ln;
         ln = (off % 4) + i;
         if (ln < 4) r[8*ln +: 8] = d[8*i +: 8];
      end
      return r;
   endfunction

   task automatic xfer(input bit wr, input int bus, input int dev, input int func, input int off,
                       input int size, input logic [31:0] wd, input bit cb, input bit hammer, input string tag);
      bit          ok, berr;
      logic [31:0] ea, old, exp_d, exp_m;
      int          erd, ewr, t;
      ok   = m_ok(bus, dev, size, cb);
      ea   = m_addr(bus, dev, func, off);
      berr = ok && (ea[10:8] == 3'b111);
      old  = peek(ea);
      if (!ok || berr) exp_d = 32'hFFFF_FFFF;
      else if (wr) exp_d = 32'h0;
      else exp_d = m_read(old, off, size);
      erd = (!ok || (wr && size == 4)) ? 0 : 1;
      ewr = (!ok || !wr) ? 0 : ((size == 4) ? 1 : (berr ? 0 : 1));
      exp_m = (ok && wr && !berr) ? ((size == 4) ? wd : m_merge(old, wd, off, size)) : old;
      rd_n = 0; wr_n = 0;
      cardbus_mode = cb; req_write = wr; req_bus = 8'(bus); req_dev = 5'(dev);
      req_func = 3'(func); req_off = 8'(off); req_size = 3'(size); req_wdata = wd;
      req_valid = 1'b1;
      @(posedge clk);
      if (ok) exp_win = m_win(bus, dev);
      @(negedge clk);
      req_valid = hammer;
      if (hammer) begin
         req_write = 1'b0; req_bus = 8'd0; req_dev = 5'd12; req_func = 3'd0;
         req_off = 8'h40; req_size = 3'd4;
      end
      t = 0;
      while (!rsp_valid && t < 80) begin
         chk(busy === 1'b1, {"R10 busy until response ", tag}, {31'd0, busy}, 32'd1);
         @(negedge clk);
         t++;
      end
      chk(rsp_valid === 1'b1, {"watchdog response ", tag}, {31'd0, rsp_valid}, 32'd1);
      chk(busy === 1'b1, {"R10 busy with response ", tag}, {31'd0, busy}, 32'd1);
      chk(rsp_err === (!ok || berr), {tag, " err"}, {31'd0, rsp_err}, {31'd0, (!ok || berr)});
      chk(rsp_rdata === exp_d, {tag, " rdata"}, rsp_rdata, exp_d);
      chk(rd_n == erd, {tag, " read count"}, 32'(rd_n), 32'(erd));
      chk(wr_n == ewr, {tag, " write count"}, 32'(wr_n), 32'(ewr));
      if (ok) chk(last_addr === ea, {tag, " address"}, last_addr, ea);
      chk(peek(ea) === exp_m, {tag, " memory word"}, peek(ea), exp_m);
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy === 1'b0, {"R10 idle after response ", tag}, {31'd0, busy}, 32'd0);
      if (hammer) begin
         for (int k = 0; k < 4; k++) begin
            chk(rsp_valid === 1'b0 && mem_req === 1'b0, "R10 busy request ignored",
                {30'd0, rsp_valid, mem_req}, 32'd0);
            @(negedge clk);
         end
         chk(rd_n == erd, "R10 no access from ignored request", 32'(rd_n), 32'(erd));
      end
   endtask

   initial begin
      #1_900_000;
      n_bad++;
      $display("FAIL watchdog: actual expired expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state, sampled while reset is still applied and after release
      chk(busy === 1'b0, "R11 busy in reset", {31'd0, busy}, 32'd0);
      chk(win_val === 32'd0, "R11 window in reset", win_val, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_req === 1'b0 && rsp_valid === 1'b0, "R11 quiet after reset", {30'd0, mem_req, rsp_valid}, 32'd0);
      chk(win_val === 32'd0, "R11 window after reset", win_val, 32'd0);
      run = 1'b1;

      // R1 R2 R7: type 0 reads, select in address (dev<10) and in window (dev>=10)
      xfer(0, 0, 3, 2, 8'h10, 4, 0, 0, 0, "R1 R7 t0 read dev3 w");
      xfer(0, 0, 12, 1, 8'h45, 1, 0, 0, 0, "R2 R7 t0 read dev12 byte lane1");
      xfer(0, 0, 9, 0, 8'h0E, 2, 0, 0, 0, "R1 R7 t0 read dev9 half lane2");
      xfer(0, 0, 15, 3, 8'h23, 1, 0, 0, 0, "R2 R7 t0 read dev15 lane3");
      xfer(0, 0, 0, 0, 8'h03, 2, 0, 0, 0, "R7 t0 half at lane3");
      // R3 type 1
      xfer(0, 5, 20, 1, 8'h22, 2, 0, 0, 0, "R3 t1 read dev20");
      xfer(0, 255, 31, 6, 8'hFD, 1, 0, 0, 0, "R3 t1 read max fields");
      // R8 writes
      xfer(1, 7, 2, 0, 8'h30, 4, 32'hCAFE_F00D, 0, 0, "R8 full write");
      xfer(1, 0, 4, 2, 8'h1B, 1, 32'h0000_00A7, 0, 0, "R8 byte write lane3");
      xfer(1, 0, 11, 5, 8'h06, 2, 32'h0000_BEEF, 0, 0, "R8 half write lane2");
      xfer(1, 0, 4, 2, 8'h19, 1, 32'hFFFF_FF3C, 0, 0, "R8 byte write lane1 same word");
      xfer(0, 0, 4, 2, 8'h18, 4, 0, 0, 0, "R8 read back merged word");
      // R4 R5 R6 rejections (window must keep its last value)
      xfer(0, 0, 16, 0, 8'h00, 4, 0, 0, 0, "R4 t0 dev16 rejected");
      xfer(1, 0, 31, 0, 8'h00, 1, 32'h55, 0, 0, "R4 t0 dev31 write rejected");
      xfer(0, 1, 16, 0, 8'h04, 4, 0, 0, 0, "R3 t1 dev16 accepted");
      xfer(0, 0, 1, 0, 8'h00, 4, 0, 1, 0, "R5 cardbus dev1 rejected");
      xfer(0, 2, 1, 0, 8'h00, 4, 0, 1, 0, "R5 cardbus t1 dev1 rejected");
      xfer(0, 0, 0, 1, 8'h08, 4, 0, 1, 0, "R5 cardbus dev0 accepted");
      xfer(0, 0, 2, 0, 8'h00, 3, 0, 0, 0, "R6 size3 rejected");
      xfer(0, 0, 2, 0, 8'h00, 0, 0, 0, 0, "R6 size0 rejected");
      xfer(1, 0, 2, 0, 8'h00, 5, 32'h1, 0, 0, "R6 size5 rejected");
      // R9 bus errors: function 7 puts ones in address bits 10:8
      xfer(0, 0, 6, 7, 8'h10, 4, 0, 0, 0, "R9 read bus error");
      xfer(1, 0, 6, 7, 8'h11, 1, 32'h42, 0, 0, "R9 partial write bus error");
      xfer(1, 3, 6, 7, 8'h10, 4, 32'h42, 0, 0, "R9 full write bus error");
      // R10 requests while busy are ignored, with longer memory latency
      lat = 3;
      xfer(0, 0, 13, 1, 8'h2C, 4, 0, 0, 1, "R10 read with busy requests");
      xfer(1, 0, 5, 0, 8'h21, 2, 32'h0000_7E7E, 0, 1, "R10 rmw with busy requests");
      lat = 0;
      for (int d = 0; d < 16; d++) begin
         xfer(0, 0, d, d % 7, (d * 13) % 256, (d % 3 == 0) ? 1 : ((d % 3 == 1) ? 2 : 4), 0, 0, 0, "R1 R2 R7 sweep");
      end
      run = 1'b0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule